// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a free-running three-bit counter. It walks a fixed, non-binary loop of five codes and takes one step on every rising clock edge. The state bits are named C (bit 2), B (bit 1) and A (bit 0), and the raw state is the only output. Other logic decodes the five codes as phases of a repeating five-step schedule.

Each state bit is loaded from its own D-style equation:

- C takes the old A.
- B takes (not B) or (not A and not C).
- A takes B and not C.

These equations also give a defined successor for the three codes outside the loop. As a result, the counter finds its way back into the loop from any power-up value or upset bit within two clocks. A synchronous active-high reset loads a code set by a parameter. That code defaults to 000, which is the first code of the loop.

Top module: `seq5_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next value of `state` is the parameter `ResetCode` (default 3'b000).
- R2: With `rst` low, `state` 3'b000 becomes 3'b010 after one rising edge.
- R3: With `rst` low, `state` 3'b010 becomes 3'b011 after one rising edge.
- R4: With `rst` low, `state` 3'b011 becomes 3'b101 after one rising edge.
- R5: With `rst` low, `state` 3'b101 becomes 3'b110 after one rising edge.
- R6: With `rst` low, `state` 3'b110 becomes 3'b000 after one rising edge, which closes the loop.
- R7: With `rst` low, unused code 3'b001 becomes 3'b110 after one rising edge.
- R8: With `rst` low, unused code 3'b100 becomes 3'b010 after one rising edge.
- R9: With `rst` low, unused code 3'b111 becomes 3'b100 after one rising edge, and then 3'b010 after the next one.
- R10: From any starting code, `state` is in the loop set {000, 010, 011, 101, 110} no later than two rising edges after reset is released. Once in that set, it never leaves it.
- R11: The state changes on every rising edge at which `rst` is low. No code is a fixed point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| state | output | 3 | Current code; bit 2 is C, bit 1 is B, bit 0 is A |

## Verification
A wrong next-state term shows at the `state` port one rising edge after the counter enters the affected code. While the counter runs in the loop, that means within five clocks. A fault on an unused code shows only when the counter starts in that code, so the bench starts one instance in each of the eight codes by way of `ResetCode`.

A missing recovery path shows in one of two ways:

- The counter sticks on an unused code, which breaks R11 on the next edge.
- The counter cycles among unused codes, which breaks R10 by the second edge after release.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

  localparam int unsigned CodeW = 3;

  typedef logic [CodeW-1:0] code_t;

  // Index of each named state bit inside the code.
  localparam int unsigned BitC = 2;
  localparam int unsigned BitB = 1;
  localparam int unsigned BitA = 0;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clear;
    logic step;
  } strobe_t;

  function automatic logic inLoop(code_t c);
    return (c == 3'b000) || (c == 3'b010) || (c == 3'b011) ||
           (c == 3'b101) || (c == 3'b110);
  endfunction

endpackage

// File: rtl/seq5_ctrl.sv
module seq5_ctrl
  import seq5_pkg::*;
(
  input  logic    rst,
  output strobe_t strobes
);

  always_comb begin
    strobes       = '0;
    strobes.clear = rst;
    strobes.step  = !rst;
  end

endmodule

// File: rtl/seq5_datapath.sv
module seq5_datapath
  import seq5_pkg::*;
#(
  parameter code_t ResetCode = 3'b000
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobes,
  output code_t   stateQ
);

  code_t nextState;
  logic  curC, curB, curA;

  assign curC = stateQ[BitC];
  assign curB = stateQ[BitB];
  assign curA = stateQ[BitA];

  // D-style equation for each bit.
  always_comb begin
    nextState       = '0;
    nextState[BitC] = curA;
    nextState[BitB] = !curB || (!curA && !curC);
    nextState[BitA] = curB && !curC;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)
      stateQ <= ResetCode;
    else if (strobes.step)
      stateQ <= nextState;
  end

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> stateQ == ResetCode);

  // R2
  step_000_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b000 |=> stateQ == 3'b010);

  // R3
  step_010_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b010 |=> stateQ == 3'b011);

  // R4
  step_011_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b011 |=> stateQ == 3'b101);

  // R5
  step_101_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b101 |=> stateQ == 3'b110);

  // R6
  step_110_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b110 |=> stateQ == 3'b000);

  // R7
  recover_001_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b001 |=> stateQ == 3'b110);

  // R8
  recover_100_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b100 |=> stateQ == 3'b010);

  // R9
  recover_111_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && stateQ == 3'b111 |=> stateQ == 3'b100);

  // R10
  loop_closed_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step && inLoop(stateQ) |=> inLoop(stateQ));

  // R11
  always_moves_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> stateQ != $past(stateQ));

endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
  import seq5_pkg::*;
#(
  parameter code_t ResetCode = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] state
);

  strobe_t strobes;
  code_t   stateQ;

  seq5_ctrl uCtrl (
    .rst     (rst),
    .strobes (strobes)
  );

  seq5_datapath #(.ResetCode(ResetCode)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  assign state = stateQ;

endmodule

// File: tb/tb_seq5_counter.sv
`timescale 1ns/1ps
module tb_seq5_counter;

  localparam int NInst = 9;  // index 0 is dut, 1..8 start at codes 0..7

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] obs [NInst];
  logic [2:0] prevObs [NInst];
  int   sinceRel [NInst];
  logic rstAtEdge = 1'b1;
  logic running = 1'b0;
  logic done = 1'b0;
  int   nChecks = 0;
  int   nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  seq5_counter dut (.clk(clk), .rst(rst), .state(obs[0]));

  for (genvar i = 0; i < 8; i++) begin : gStart
    seq5_counter #(.ResetCode(3'(i))) uStart (
      .clk(clk), .rst(rst), .state(obs[i+1]));
  end

  function automatic logic [2:0] refNext(logic [2:0] c);
    case (c)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic string tagFor(logic [2:0] c);
    case (c)
      3'b000: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b101: return "R5";
      3'b110: return "R6";
      3'b001: return "R7";
      3'b100: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic refLoop(logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b011 ||
           c == 3'b101 || c == 3'b110;
  endfunction

  function automatic logic [2:0] resetOf(int idx);
    return (idx == 0) ? 3'b000 : 3'(idx - 1);
  endfunction

  task automatic check(string tag, int idx, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s inst %0d: actual %b expected %b", tag, idx, act, exp);
    end
  endtask

  always @(posedge clk) rstAtEdge <= rst;

  always @(negedge clk) begin
    if (running) begin
      for (int k = 0; k < NInst; k++) begin
        if (rstAtEdge) begin
          check("R1", k, obs[k], resetOf(k));
          sinceRel[k] = 0;
        end else begin
          check(tagFor(prevObs[k]), k, obs[k], refNext(prevObs[k]));
          nChecks++;
          if (obs[k] === prevObs[k]) begin
            nFails++;
            $display("FAIL R11 inst %0d: actual %b expected change from %b",
                     k, obs[k], prevObs[k]);
          end
          sinceRel[k] = sinceRel[k] + 1;
          if (sinceRel[k] >= 2) begin
            nChecks++;
            if (refLoop(obs[k]) !== 1'b1) begin
              nFails++;
              $display("FAIL R10 inst %0d: actual %b expected a loop code",
                       k, obs[k]);
            end
          end
        end
        prevObs[k] = obs[k];
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NInst; k++) sinceRel[k] = 0;
    rst = 1'b1;
    @(negedge clk);
    running = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // directed: single-cycle reset pulse, then back-to-back pulses
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    // random reset pulses mixed into free running
    for (int n = 0; n < 600; n++) begin
      rst = (($urandom % 13) == 0);
      @(negedge clk);
    end
    rst = 1'b0;
    repeat (10) @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule